// File: doc/BRIEF.md
# Timer/counter with match and capture

This block is a peripheral timer with a synchronous register port. Its counter advances either from the peripheral clock, divided by a programmable prescaler, or from qualified edges on one selected external input. Four compare values are checked against the counter. Each one can set a sticky interrupt flag, zero the counter on its next tick, or halt counting. Each also drives its own output pin, which a 2-bit action field can set, clear or toggle.

Four capture channels watch the external inputs. The inputs pass through a two-flop synchronizer and an edge detector. On a qualifying edge, a channel copies the running count into its capture register and raises its flag. When one input serves as the count source, the other inputs keep working as capture channels.

Register words (5-bit address): 0 control ([0] run enable, [1] soft reset); 1 source ([1:0] edge, [3:2] input index); 2 prescale limit; 3 prescale count; 4 counter; 5 flags (match flags in [3:0], capture flags in [7:4], write 1 to clear); 6 interrupt enable (same layout); 7 match control ([2i] reset, [2i+1] stop); 8 capture edge select (2 bits per channel); 9 output action (2 bits per match); 10 output state; 16+i compare value i; 24+i capture value i. Edge codes are 0 off, 1 rising, 2 falling and 3 both. In the source word, edge code 0 selects prescaled clock counting.

Top module: `tmr_match_capture`

## Requirements
- R1: After reset, every register reads 0, the match outputs are 0 and the interrupt is 0.
- R2: In clock mode with the run bit set and prescale limit P, the counter advances by one every P+1 clocks. The prescale count runs from 0 to P and then restarts from 0.
- R3: In counting mode (edge code 1, 2 or 3), each qualified edge on the selected input advances the counter once (with P=0). The clock alone does not move the counter. An edge takes effect on the third clock edge after the input changes.
- R4: While soft reset (control bit 1) is set, the counter and the prescale count stay at 0.
- R5: A match flag is set on the clock edge where the counter takes the compare value. The interrupt output is high when any flag that is enabled is set.
- R6: When the reset bit of a match is set, the counter returns to 0 on the tick after it reaches that value. This gives a cycle of value+1 counts.
- R7: When the stop bit of a match is set, the run bit clears when the counter reaches that value, and the counter holds that value.
- R8: On a match, the output action code 0 leaves the output unchanged, 1 drives it low, 2 drives it high and 3 toggles it.
- R9: A capture channel stores the counter value on each edge its code selects, and sets flag bit 4+i. A channel with code 0 ignores its input.
- R10: Writing 1 to a flag bit clears it. Writing 0 leaves it unchanged.
- R11: With the run bit clear, the counter does not change.
- R12: While one input is the count source, another input still captures the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Register word address |
| wdata | input | W | Write data |
| rdata | output | W | Read data for the addressed word (combinational) |
| cap_in | input | NC | External capture and count inputs |
| match_out | output | NM | Match-driven output pins |
| irq | output | 1 | Combined interrupt request |

## Verification
On every cycle, the assertions check the following. Soft reset pins the counter and the prescaler at zero. The counter only steps by one, wraps to zero, or takes a written value. A disabled counter holds. The run bit only falls through a write or a stop match. The outputs and the capture registers change only on their own events, and a capture register then holds the previous count. A rising interrupt has a cause. The bench scenarios cover the arithmetic: the exact count sequence over a sweep of prescale and wrap values, each output action code, the capture values under each edge selection, and edge counting with a second input still capturing.

// File: rtl/tmr_match_capture.sv
module tmr_match_capture #(
  parameter int W  = 32,
  parameter int NM = 4,
  parameter int NC = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [4:0]    addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata,
  input  logic [NC-1:0] cap_in,
  output logic [NM-1:0] match_out,
  output logic          irq
);
  localparam int SW = (NC > 1) ? $clog2(NC) : 1;
  localparam int NF = NM + NC;
  localparam logic [4:0] A_CTRL = 5'd0, A_MODE = 5'd1, A_PRESC = 5'd2, A_PCNT = 5'd3,
                         A_COUNT = 5'd4, A_FLAGS = 5'd5, A_IEN = 5'd6, A_MCTL = 5'd7,
                         A_CCTL = 5'd8, A_OCTL = 5'd9, A_OUT = 5'd10, A_MAT = 5'd16,
                         A_CAP = 5'd24;

  logic          en, sres;
  logic [1:0]    src_edge;
  logic [SW-1:0] src_sel;
  logic [W-1:0]  presc, pcnt, tc, tc_nxt;
  logic [NF-1:0] flags, ien;
  logic [2*NM-1:0] mctl, octl;
  logic [2*NC-1:0] cctl;
  logic [W-1:0]  mr [NM];
  logic [W-1:0]  cr [NC];
  logic [NC-1:0] s1, s2, sp, rise, fall, cev;
  logic [NM-1:0] mev;
  logic          src_ev, event_ok, pwrap, tick, rst_hit, stop_hit;

  function automatic logic edge_hit(input logic [1:0] m, input logic r, input logic f);
    return (m[0] & r) | (m[1] & f);
  endfunction

  assign rise     = s2 & ~sp;
  assign fall     = ~s2 & sp;
  assign src_ev   = edge_hit(src_edge, rise[src_sel], fall[src_sel]);
  assign event_ok = en && !sres && ((src_edge == 2'd0) || src_ev);
  assign pwrap    = (pcnt == presc);
  assign tick     = event_ok && pwrap;
  assign tc_nxt   = rst_hit ? '0 : tc + 1'b1;
  assign irq      = |(flags & ien);

  always_comb begin
    rst_hit  = 1'b0;
    stop_hit = 1'b0;
    for (int i = 0; i < NM; i++) begin
      if (tc == mr[i] && mctl[2*i]) rst_hit = 1'b1;
      mev[i] = tick && (tc_nxt == mr[i]);
      if (mev[i] && mctl[2*i+1]) stop_hit = 1'b1;
    end
    for (int i = 0; i < NC; i++)
      cev[i] = edge_hit(cctl[2*i +: 2], rise[i], fall[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0; s2 <= '0; sp <= '0;
    end else begin
      s1 <= cap_in; s2 <= s1; sp <= s2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en <= 1'b0; sres <= 1'b0; src_edge <= '0; src_sel <= '0;
      presc <= '0; pcnt <= '0; tc <= '0; flags <= '0; ien <= '0;
      mctl <= '0; octl <= '0; cctl <= '0; match_out <= '0;
      for (int i = 0; i < NM; i++) mr[i] <= '0;
      for (int i = 0; i < NC; i++) cr[i] <= '0;
    end else begin
      if (wr_en && addr == A_CTRL) begin
        en <= wdata[0]; sres <= wdata[1];
      end else if (stop_hit) en <= 1'b0;

      if (wr_en && addr == A_MODE) begin
        src_edge <= wdata[1:0]; src_sel <= wdata[2 +: SW];
      end
      if (wr_en && addr == A_PRESC) presc <= wdata;
      if (wr_en && addr == A_IEN)   ien   <= wdata[NF-1:0];
      if (wr_en && addr == A_MCTL)  mctl  <= wdata[2*NM-1:0];
      if (wr_en && addr == A_CCTL)  cctl  <= wdata[2*NC-1:0];
      if (wr_en && addr == A_OCTL)  octl  <= wdata[2*NM-1:0];

      if (sres)                          pcnt <= '0;
      else if (wr_en && addr == A_PCNT)  pcnt <= wdata;
      else if (event_ok)                 pcnt <= pwrap ? '0 : pcnt + 1'b1;

      if (sres)                          tc <= '0;
      else if (wr_en && addr == A_COUNT) tc <= wdata;
      else if (tick)                     tc <= tc_nxt;

      flags <= (flags & ~((wr_en && addr == A_FLAGS) ? wdata[NF-1:0] : '0)) | {cev, mev};

      if (wr_en && addr == A_OUT) match_out <= wdata[NM-1:0];
      else
        for (int i = 0; i < NM; i++)
          if (mev[i])
            case (octl[2*i +: 2])
              2'd1:    match_out[i] <= 1'b0;
              2'd2:    match_out[i] <= 1'b1;
              2'd3:    match_out[i] <= ~match_out[i];
              default: ;
            endcase

      for (int i = 0; i < NM; i++)
        if (wr_en && addr == A_MAT + 5'(i)) mr[i] <= wdata;
      for (int i = 0; i < NC; i++)
        if (cev[i]) cr[i] <= tc;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_CTRL:  rdata = W'({sres, en});
      A_MODE:  rdata = W'({src_sel, src_edge});
      A_PRESC: rdata = presc;
      A_PCNT:  rdata = pcnt;
      A_COUNT: rdata = tc;
      A_FLAGS: rdata = W'(flags);
      A_IEN:   rdata = W'(ien);
      A_MCTL:  rdata = W'(mctl);
      A_CCTL:  rdata = W'(cctl);
      A_OCTL:  rdata = W'(octl);
      A_OUT:   rdata = W'(match_out);
      default: begin
        for (int i = 0; i < NM; i++) if (addr == A_MAT + 5'(i)) rdata = mr[i];
        for (int i = 0; i < NC; i++) if (addr == A_CAP + 5'(i)) rdata = cr[i];
      end
    endcase
  end
endmodule

module tmr_match_capture_chk #(
  parameter int W  = 32,
  parameter int NM = 4,
  parameter int NC = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [4:0]    addr,
  input logic          en,
  input logic          sres,
  input logic [W-1:0]  tc,
  input logic [W-1:0]  pcnt,
  input logic [NM-1:0] mev,
  input logic [NC-1:0] cev,
  input logic [2*NM-1:0] mctl,
  input logic [NM-1:0] match_out,
  input logic          irq,
  input logic [W-1:0]  cr [NC]
);
  logic [NM-1:0] stopmask;
  always_comb for (int i = 0; i < NM; i++) stopmask[i] = mctl[2*i+1];

  a_r4_soft_reset_holds: assert property (@(posedge clk) disable iff (!rst_n)
    sres |=> (tc == '0 && pcnt == '0));

  a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !sres && !(wr_en && addr == 5'd4)) |=> $stable(tc));

  a_r2_step_or_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(tc) && !$past(sres) && !$past(wr_en && addr == 5'd4))
      |-> (tc == W'($past(tc) + 1'b1) || tc == '0));

  a_r7_stop_clears_run: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en) |-> ($past(wr_en && addr == 5'd0) || $past(|(mev & stopmask))));

  a_r8_output_cause: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(match_out) |-> ($past(|mev) || $past(wr_en && addr == 5'd10)));

  a_r5_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(|mev) || $past(|cev) || $past(wr_en && addr == 5'd6)));

  for (genvar i = 0; i < NC; i++) begin : g_cap
    a_r9_capture_value: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cr[i]) |-> ($past(cev[i]) && cr[i] == $past(tc)));
  end
endmodule

bind tmr_match_capture tmr_match_capture_chk #(.W(W), .NM(NM), .NC(NC)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .en(en), .sres(sres),
  .tc(tc), .pcnt(pcnt), .mev(mev), .cev(cev), .mctl(mctl),
  .match_out(match_out), .irq(irq), .cr(cr)
);

// File: tb/tmr_match_capture_tb.sv
module tmr_match_capture_tb;
  localparam int W = 8;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [4:0] addr = '0;
  logic [W-1:0] wdata = '0, rdata;
  logic [3:0] cap_in = '0;
  logic [3:0] match_out;
  logic irq;
  int vectors = 0, fails = 0, cyc = 0, e0 = 0;
  bit done = 0;

  tmr_match_capture #(.W(W), .NM(4), .NC(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .cap_in(cap_in), .match_out(match_out), .irq(irq));

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk); wr_en = 1'b1; addr = 5'(a); wdata = W'(d);
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    addr = 5'(a); #1; v = int'(rdata);
  endtask

  task automatic start();
    wr(0, 1); e0 = cyc;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    int v, t, exp_o;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 28; a++) begin
      if (a <= 10 || (a >= 16 && a < 20) || a >= 24) begin
        rd(a, v); chk($sformatf("R1 reg %0d", a), v, 0);
      end
    end
    chk("R1 match_out", int'(match_out), 0);
    chk("R1 irq", int'(irq), 0);

    // R2 / R6 sweep of prescale and wrap value
    for (int p = 0; p < 4; p++)
      for (int m = 1; m < 5; m++) begin
        wr(0, 2); wr(1, 0); wr(7, 1); wr(16, m); wr(2, p); start();
        for (int n = 1; n <= 24; n++) begin
          @(negedge clk); rd(4, v);
          chk($sformatf("R2/R6 p=%0d m=%0d n=%0d", p, m, n), v, (n / (p + 1)) % (m + 1));
        end
      end

    // R7 stop, R5 flag timing and irq, R10 clear
    wr(0, 2); wr(7, 8); wr(17, 5); wr(2, 0); wr(5, 255); start();
    repeat (4) @(negedge clk);
    rd(5, v); chk("R5 flag1 before match", (v >> 1) & 1, 0);
    @(negedge clk);
    rd(5, v); chk("R5 flag1 at match", (v >> 1) & 1, 1);
    repeat (5) @(negedge clk);
    rd(4, v); chk("R7 count held", v, 5);
    rd(0, v); chk("R7 run bit cleared", v, 0);
    chk("R5 irq masked", int'(irq), 0);
    wr(6, 2); #1; chk("R5 irq enabled", int'(irq), 1);
    wr(5, 0); rd(5, v); chk("R10 write 0 keeps flag", (v >> 1) & 1, 1);
    wr(5, 2); rd(5, v); chk("R10 write 1 clears flag", (v >> 1) & 1, 0);
    chk("R10 irq drops", int'(irq), 0);

    // R11 idle hold
    wr(4, 9); repeat (10) @(negedge clk);
    rd(4, v); chk("R11 disabled count holds", v, 9);

    // R8 output actions: m0 toggle, m1 set, m2 clear, m3 none
    wr(0, 2); wr(6, 0); wr(7, 8'h80);
    wr(16, 2); wr(17, 3); wr(18, 4); wr(19, 5);
    wr(9, 8'h1B); wr(10, 4'b1100); start();
    exp_o = 4'b1100;
    for (int n = 1; n <= 10; n++) begin
      @(negedge clk);
      if (n == 2) exp_o ^= 1;
      if (n == 3) exp_o |= 2;
      if (n == 4) exp_o &= ~4;
      chk($sformatf("R8 outputs n=%0d", n), int'(match_out), exp_o);
    end

    // R9 capture on selected edges
    wr(0, 2); wr(7, 0); wr(8, 8'h34); wr(5, 255); start();
    repeat (3) @(negedge clk);
    t = cyc - e0; cap_in[1] = 1'b1;
    repeat (5) @(negedge clk);
    rd(25, v); chk("R9 ch1 rising capture", v, t + 2);
    rd(5, v); chk("R9 ch1 flag", (v >> 5) & 1, 1);
    cap_in[1] = 1'b0; repeat (5) @(negedge clk);
    rd(25, v); chk("R9 ch1 ignores falling", v, t + 2);
    t = cyc - e0; cap_in[2] = 1'b1; repeat (6) @(negedge clk);
    rd(26, v); chk("R9 ch2 rising", v, t + 2);
    t = cyc - e0; cap_in[2] = 1'b0; repeat (6) @(negedge clk);
    rd(26, v); chk("R9 ch2 falling", v, t + 2);
    cap_in[3] = 1'b1; repeat (4) @(negedge clk); cap_in[3] = 1'b0; repeat (4) @(negedge clk);
    rd(27, v); chk("R9 ch3 off ignored", v, 0);
    rd(5, v); chk("R9 ch3 flag stays clear", (v >> 7) & 1, 0);

    // R3 / R12 counting mode
    wr(0, 2); wr(8, 8'h10); wr(1, 1); wr(2, 0); start();
    for (int k = 0; k < 7; k++) begin
      cap_in[0] = 1'b1; repeat (2) @(negedge clk);
      cap_in[0] = 1'b0; repeat (2) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    rd(4, v); chk("R3 rising edges counted", v, 7);
    repeat (20) @(negedge clk);
    rd(4, v); chk("R3 clock alone ignored", v, 7);
    cap_in[2] = 1'b1; repeat (5) @(negedge clk);
    rd(26, v); chk("R12 capture during count mode", v, 7);
    cap_in[2] = 1'b0;
    wr(0, 2); wr(1, 15); start();
    for (int k = 0; k < 4; k++) begin
      cap_in[3] = 1'b1; repeat (3) @(negedge clk);
      cap_in[3] = 1'b0; repeat (3) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    rd(4, v); chk("R3 both edges counted", v, 8);

    // R4 soft reset hold
    wr(0, 2); wr(1, 0); wr(2, 2); start();
    repeat (10) @(negedge clk);
    wr(0, 3);
    for (int n = 0; n < 8; n++) begin
      @(negedge clk);
      rd(4, v); chk("R4 count held at zero", v, 0);
      rd(3, v); chk("R4 prescale held at zero", v, 0);
    end
    start();
    repeat (9) @(negedge clk);
    rd(4, v); chk("R4 resumes after release", v, 3);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule